// File: doc/BRIEF.md
# Complementary Gate-Drive Output Stage with Kill Handling

This block sits after a PWM counter. It turns the counter's raw PWM level into two complementary gate-drive lanes, a primary lane (`gate_p`) and a complementary lane (`gate_n`). Each lane has its own source selector, and each applies its own dead time to its rising edge. Each lane also has an output enable, so a lane can be left undriven. The selector and the dead-time count of each lane are double-buffered. At a terminal count they can be exchanged with their alternate values.

A small state machine handles protective shutdown. It forces both lanes to a programmed safe pattern while the counter is disabled or stopped, and on a kill event. The kill mode decides when shutdown starts:

- **Next clock:** the safe pattern appears one clock after kill is seen.
- **Immediate:** the safe pattern appears combinationally, in the same cycle.
- **Terminal-count synchronous:** shutdown waits for the next terminal count, plus the primary lane's dead time.
- **Staggered:** the primary lane is suppressed at once, and the complementary lane one dead time later.

When kill is released, output resumes only at a terminal count, so the first period after release is always a whole one.

Kill state machine:

| State | Lanes suppressed | Meaning |
|---|---|---|
| `ST_RUN` | none | Normal output |
| `ST_ARMED` | none | Kill latched in terminal-count synchronous mode; waiting for a terminal count |
| `ST_TC_WAIT` | none | Terminal count seen; counting the primary lane's dead time |
| `ST_STAGGER` | primary only | Staggered kill; counting the complementary lane's dead time |
| `ST_SAFE` | both | Safe pattern on both lanes |
| `ST_REARM` | both | Kill released; waiting for a terminal count |

Transitions of the kill state machine:

- From any state other than `ST_SAFE`, losing enable or run goes to `ST_SAFE`.
- `ST_RUN` leaves on kill:
  - to `ST_SAFE` in next-clock or immediate mode;
  - to `ST_ARMED` in terminal-count synchronous mode;
  - to `ST_STAGGER` in staggered mode, or to `ST_SAFE` if the complementary dead time is 0.
- `ST_ARMED` goes on a terminal count to `ST_TC_WAIT`, or to `ST_SAFE` if the primary dead time is 0.
- `ST_TC_WAIT` goes to `ST_SAFE` when its timer expires.
- `ST_STAGGER` goes to `ST_SAFE` when its timer expires.
- `ST_SAFE` goes to `ST_REARM` once kill is low and the counter is enabled and running.
- `ST_REARM` returns to `ST_SAFE` on kill, and goes to `ST_RUN` on a terminal count.
- Reset enters `ST_SAFE`.

Top module: `pwm_gate_drive`

## Requirements
- R1: Source codes 0, 1, 2 and 3 give a lane the constant 0, the constant 1, the PWM level and the inverted PWM level. With a dead time of 0, the lane shows the result one clock after the inputs change.
- R2: Source code 4 leaves a lane undriven: its enable is 0 and its data reads 0. Every other code drives the lane (enable 1) whenever the lane is not suppressed.
- R3: Source code 5 takes the external code: 0 gives 0, 1 gives 1, and 2 or 3 give the PWM level.
- R4: A lane's rising edge comes its dead-time count of clocks later than it would with a count of 0. A falling edge appears after one clock whatever the count.
- R5: While the counter enable is low, the active and alternate registers for source and dead time load from their config inputs. While enabled, a terminal count with swap enabled exchanges them. With swap disabled they hold.
- R6: The safe pattern comes from the 2-bit polarity field: bit 0 sets the primary lane and bit 1 the complementary lane. Both lanes are driven to this pattern from reset, and from one clock after enable or run goes low.
- R7: Kill mode 0 applies the safe pattern one clock after kill is sampled. Kill mode 1 applies it combinationally, in the same cycle.
- R8: In kill mode 2, suppression of both lanes starts a number of clocks after the edge that samples the next terminal count. That number is the primary dead time.
- R9: In kill mode 3, the primary lane is suppressed one clock after kill. The complementary lane follows after a further number of clocks equal to its dead time.
- R10: After kill is released, or after reset, both lanes stay at the safe pattern until the clock edge that samples a terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | Raw PWM level from the counter |
| tc_pulse | input | 1 | Terminal-count strobe, one clock wide |
| kill_in | input | 1 | Kill request, already filtered |
| cnt_enable | input | 1 | Counter enabled |
| cnt_running | input | 1 | Counter running |
| ext_code | input | 2 | External modulation code for source 5 |
| sel_p | input | 3 | Primary lane source, active value |
| sel_n | input | 3 | Complementary lane source, active value |
| sel_p_alt | input | 3 | Primary lane source, alternate value |
| sel_n_alt | input | 3 | Complementary lane source, alternate value |
| dt_p | input | DT_W | Primary lane dead time, active value |
| dt_n | input | DT_W | Complementary lane dead time, active value |
| dt_p_alt | input | DT_W | Primary lane dead time, alternate value |
| dt_n_alt | input | DT_W | Complementary lane dead time, alternate value |
| swap_en | input | 1 | Enable exchange at terminal count |
| safe_pol | input | 2 | Safe pattern: bit 0 primary, bit 1 complementary |
| kill_mode | input | 2 | 0 next clock, 1 immediate, 2 terminal-count synchronous, 3 staggered |
| gate_p | output | 1 | Primary lane |
| gate_n | output | 1 | Complementary lane |
| oe_p | output | 1 | Primary lane output enable |
| oe_n | output | 1 | Complementary lane output enable |

## Verification
The assertions take three things for granted:

- `tc_pulse` lasts one clock.
- The config fields change only while the counter enable is low.
- The safe polarity does not change in the cycle after enable or run drops.

The stimulus keeps within these limits in three ways:

- It rewrites the configuration only from a task that first lowers the enable and waits for the registers to load.
- It raises the terminal count for exactly one clock, from one clock edge to the next.
- It holds the polarity fixed within each test.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

    typedef enum logic [2:0] {
        SRC_ZERO  = 3'd0,
        SRC_ONE   = 3'd1,
        SRC_PWM   = 3'd2,
        SRC_PWM_N = 3'd3,
        SRC_HIZ   = 3'd4,
        SRC_EXT   = 3'd5
    } src_sel_e;

    typedef enum logic [1:0] {
        KM_NEXT    = 2'd0,
        KM_IMM     = 2'd1,
        KM_TCSYNC  = 2'd2,
        KM_STAGGER = 2'd3
    } kill_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_ARMED,
        ST_TC_WAIT,
        ST_STAGGER,
        ST_SAFE,
        ST_REARM
    } kill_st_e;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/pgd_line_src.sv
module pgd_line_src
    import pgd_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       pwm,
    input  logic [1:0] ext_code,
    output logic       level,
    output logic       drive
);

    always_comb begin
        level = 1'b0;
        drive = 1'b1;
        case (src_sel_e'(sel))
            SRC_ZERO:  level = 1'b0;
            SRC_ONE:   level = 1'b1;
            SRC_PWM:   level = pwm;
            SRC_PWM_N: level = ~pwm;
            SRC_HIZ:   drive = 1'b0;
            SRC_EXT: begin
                case (ext_code)
                    2'd0:    level = 1'b0;
                    2'd1:    level = 1'b1;
                    default: level = pwm;
                endcase
            end
            default:   level = 1'b0;
        endcase
    end

endmodule

// File: rtl/pgd_dead_time.sv
module pgd_dead_time #(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_lvl,
    input  logic [DT_W-1:0] dt_cnt,
    output logic            out_lvl
);

    logic [DT_W-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_lvl <= 1'b0;
            wait_q  <= '0;
        end else if (!in_lvl) begin
            out_lvl <= 1'b0;
            wait_q  <= '0;
        end else if (!out_lvl) begin
            if (wait_q >= dt_cnt) begin
                out_lvl <= 1'b1;
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end

    AST_FALL_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !in_lvl |=> !out_lvl); // R4
    AST_RISE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_lvl) |-> $past(in_lvl)); // R4
    AST_ZERO_DT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_cnt == '0 && in_lvl) |=> out_lvl); // R4

endmodule

// File: rtl/pgd_kill_fsm.sv
module pgd_kill_fsm
    import pgd_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_ok,
    input  logic            kill,
    input  logic            tc,
    input  logic [1:0]      mode,
    input  logic [DT_W-1:0] dt_p,
    input  logic [DT_W-1:0] dt_n,
    output logic            sup_p,
    output logic            sup_n
);

    kill_st_e        state, state_nxt;
    logic [DT_W-1:0] tmr;
    logic [DT_W:0]   tmr_inc;
    logic            done_p, done_n;

    assign tmr_inc = {1'b0, tmr} + 1'b1;
    assign done_p  = tmr_inc >= {1'b0, dt_p};
    assign done_n  = tmr_inc >= {1'b0, dt_n};

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (!run_ok) begin
                    state_nxt = ST_SAFE;
                end else if (kill) begin
                    unique case (kill_mode_e'(mode))
                        KM_NEXT, KM_IMM: state_nxt = ST_SAFE;
                        KM_TCSYNC:       state_nxt = ST_ARMED;
                        KM_STAGGER:      state_nxt = (dt_n == '0) ? ST_SAFE : ST_STAGGER;
                    endcase
                end
            end
            ST_ARMED: begin
                if (!run_ok)      state_nxt = ST_SAFE;
                else if (tc)      state_nxt = (dt_p == '0) ? ST_SAFE : ST_TC_WAIT;
            end
            ST_TC_WAIT: begin
                if (!run_ok || done_p) state_nxt = ST_SAFE;
            end
            ST_STAGGER: begin
                if (!run_ok || done_n) state_nxt = ST_SAFE;
            end
            ST_SAFE: begin
                if (run_ok && !kill) state_nxt = ST_REARM;
            end
            ST_REARM: begin
                if (!run_ok || kill) state_nxt = ST_SAFE;
                else if (tc)         state_nxt = ST_RUN;
            end
            default: state_nxt = ST_SAFE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SAFE;
            tmr   <= '0;
        end else begin
            state <= state_nxt;
            tmr   <= (state_nxt != state) ? '0 : tmr + 1'b1;
        end
    end

    always_comb begin
        sup_p = 1'b0;
        sup_n = 1'b0;
        unique case (state)
            ST_RUN, ST_ARMED, ST_TC_WAIT: begin
                sup_p = 1'b0;
                sup_n = 1'b0;
            end
            ST_STAGGER: begin
                sup_p = 1'b1;
                sup_n = 1'b0;
            end
            ST_SAFE, ST_REARM: begin
                sup_p = 1'b1;
                sup_n = 1'b1;
            end
            default: begin
                sup_p = 1'b1;
                sup_n = 1'b1;
            end
        endcase
    end

    AST_STAGGER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        sup_n |-> sup_p); // R9
    AST_RESUME_ON_TC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sup_p) |-> $past(tc)); // R10
    AST_TCSYNC_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && run_ok && kill && mode == KM_TCSYNC) |=> !sup_p); // R8

endmodule

// File: rtl/pwm_gate_drive.sv
module pwm_gate_drive
    import pgd_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic            tc_pulse,
    input  logic            kill_in,
    input  logic            cnt_enable,
    input  logic            cnt_running,
    input  logic [1:0]      ext_code,
    input  logic [2:0]      sel_p,
    input  logic [2:0]      sel_n,
    input  logic [2:0]      sel_p_alt,
    input  logic [2:0]      sel_n_alt,
    input  logic [DT_W-1:0] dt_p,
    input  logic [DT_W-1:0] dt_n,
    input  logic [DT_W-1:0] dt_p_alt,
    input  logic [DT_W-1:0] dt_n_alt,
    input  logic            swap_en,
    input  logic [1:0]      safe_pol,
    input  logic [1:0]      kill_mode,
    output logic            gate_p,
    output logic            gate_n,
    output logic            oe_p,
    output logic            oe_n
);

    logic [2:0]      cfg_sel     [LANES];
    logic [2:0]      cfg_sel_alt [LANES];
    logic [DT_W-1:0] cfg_dt      [LANES];
    logic [DT_W-1:0] cfg_dt_alt  [LANES];
    logic [DT_W-1:0] dt_cur      [LANES];
    logic [LANES-1:0] sup, gate, oe;
    logic run_ok, imm_kill;

    assign cfg_sel[0]     = sel_p;
    assign cfg_sel[1]     = sel_n;
    assign cfg_sel_alt[0] = sel_p_alt;
    assign cfg_sel_alt[1] = sel_n_alt;
    assign cfg_dt[0]      = dt_p;
    assign cfg_dt[1]      = dt_n;
    assign cfg_dt_alt[0]  = dt_p_alt;
    assign cfg_dt_alt[1]  = dt_n_alt;

    assign run_ok   = cnt_enable & cnt_running;
    assign imm_kill = kill_in && (kill_mode == KM_IMM);

    pgd_kill_fsm #(.DT_W(DT_W)) u_kill (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_ok (run_ok),
        .kill   (kill_in),
        .tc     (tc_pulse),
        .mode   (kill_mode),
        .dt_p   (dt_cur[0]),
        .dt_n   (dt_cur[1]),
        .sup_p  (sup[0]),
        .sup_n  (sup[1])
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [2:0]      sel_act, sel_bak;
        logic [DT_W-1:0] dt_act, dt_bak;
        logic            lvl, drv, shaped, forced;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_act <= '0;
                sel_bak <= '0;
                dt_act  <= '0;
                dt_bak  <= '0;
            end else if (!cnt_enable) begin
                sel_act <= cfg_sel[i];
                sel_bak <= cfg_sel_alt[i];
                dt_act  <= cfg_dt[i];
                dt_bak  <= cfg_dt_alt[i];
            end else if (tc_pulse && swap_en) begin
                sel_act <= sel_bak;
                sel_bak <= sel_act;
                dt_act  <= dt_bak;
                dt_bak  <= dt_act;
            end
        end

        assign dt_cur[i] = dt_act;

        pgd_line_src u_src (
            .sel      (sel_act),
            .pwm      (pwm_in),
            .ext_code (ext_code),
            .level    (lvl),
            .drive    (drv)
        );

        pgd_dead_time #(.DT_W(DT_W)) u_dt (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_lvl  (lvl),
            .dt_cnt  (dt_act),
            .out_lvl (shaped)
        );

        assign forced  = sup[i] | imm_kill;
        assign gate[i] = forced ? safe_pol[i] : (drv & shaped);
        assign oe[i]   = forced | drv;
    end

    assign gate_p = gate[0];
    assign gate_n = gate[1];
    assign oe_p   = oe[0];
    assign oe_n   = oe[1];

    AST_SAFE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> (gate_p == safe_pol[0] && gate_n == safe_pol[1] && oe_p && oe_n)); // R6
    AST_IMM_KILL_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_in && kill_mode == KM_IMM) |-> (gate_p == safe_pol[0] && gate_n == safe_pol[1])); // R7
    AST_UNDRIVEN_LOW_P: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_p |-> !gate_p); // R2
    AST_UNDRIVEN_LOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !gate_n); // R2

endmodule

// File: tb/sim_pwm_gate_drive.sv
module sim_pwm_gate_drive;

    localparam int DT_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pwm_in = 0, tc_pulse = 0, kill_in = 0, cnt_enable = 0, cnt_running = 0;
    logic [1:0] ext_code = 0, safe_pol = 0, kill_mode = 0;
    logic [2:0] sel_p = 0, sel_n = 0, sel_p_alt = 0, sel_n_alt = 0;
    logic [DT_W-1:0] dt_p = 0, dt_n = 0, dt_p_alt = 0, dt_n_alt = 0;
    logic swap_en = 0;
    logic gate_p, gate_n, oe_p, oe_n;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    pwm_gate_drive #(.DT_W(DT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .tc_pulse(tc_pulse),
        .kill_in(kill_in), .cnt_enable(cnt_enable), .cnt_running(cnt_running),
        .ext_code(ext_code), .sel_p(sel_p), .sel_n(sel_n),
        .sel_p_alt(sel_p_alt), .sel_n_alt(sel_n_alt),
        .dt_p(dt_p), .dt_n(dt_n), .dt_p_alt(dt_p_alt), .dt_n_alt(dt_n_alt),
        .swap_en(swap_en), .safe_pol(safe_pol), .kill_mode(kill_mode),
        .gate_p(gate_p), .gate_n(gate_n), .oe_p(oe_p), .oe_n(oe_n)
    );

    // {sel_p, sel_n, ext_code, pwm, exp gate_p, exp gate_n, exp oe_p, exp oe_n}
    localparam logic [12:0] VEC [8] = '{
        {3'd0, 3'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {3'd2, 3'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {3'd2, 3'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {3'd4, 3'd2, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {3'd5, 3'd5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {3'd5, 3'd3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {3'd5, 3'd4, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {3'd5, 3'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic configure(input logic [2:0] sp, input logic [2:0] sn,
                             input logic [2:0] spa, input logic [2:0] sna,
                             input logic [DT_W-1:0] dp, input logic [DT_W-1:0] dn,
                             input logic sw, input logic [1:0] pol, input logic [1:0] km);
        cnt_enable = 0; cnt_running = 0; kill_in = 0; tc_pulse = 0;
        sel_p = sp; sel_n = sn; sel_p_alt = spa; sel_n_alt = sna;
        dt_p = dp; dt_n = dn; dt_p_alt = dp; dt_n_alt = dn;
        swap_en = sw; safe_pol = pol; kill_mode = km;
        nclk(2);
    endtask

    task automatic start_run();
        cnt_enable = 1; cnt_running = 1;
        nclk(1);
        tc_pulse = 1;
        nclk(1);
        tc_pulse = 0;
    endtask

    task automatic pulse_tc();
        tc_pulse = 1;
        nclk(1);
        tc_pulse = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R6: safe pattern from reset, polarity 2 -> primary low, complementary high
        safe_pol = 2'd2;
        nclk(3);
        chk("R6", "reset gate_p", gate_p, 1'b0);
        chk("R6", "reset gate_n", gate_n, 1'b1);
        chk("R6", "reset oe_p", oe_p, 1'b1);
        rst_n = 1;
        nclk(2);

        // R1 R2 R3: source select table
        for (int v = 0; v < 8; v++) begin
            pwm_in = VEC[v][4];
            ext_code = VEC[v][6:5];
            configure(VEC[v][12:10], VEC[v][9:7], 3'd0, 3'd0, '0, '0, 1'b0, 2'd0, 2'd0);
            start_run();
            nclk(2);
            chk("R1/R2/R3", $sformatf("vec%0d gate_p", v), gate_p, VEC[v][3]);
            chk("R1/R2/R3", $sformatf("vec%0d gate_n", v), gate_n, VEC[v][2]);
            chk("R2", $sformatf("vec%0d oe_p", v), oe_p, VEC[v][1]);
            chk("R2", $sformatf("vec%0d oe_n", v), oe_n, VEC[v][0]);
        end

        // R4: dead time 3 on primary, 0 on complementary
        pwm_in = 0;
        configure(3'd2, 3'd3, 3'd2, 3'd3, 8'd3, 8'd0, 1'b0, 2'd0, 2'd0);
        start_run();
        nclk(2);
        pwm_in = 1;
        nclk(1);
        chk("R4", "gate_n falls after one clock", gate_n, 1'b0);
        chk("R4", "gate_p held clk1", gate_p, 1'b0);
        nclk(2);
        chk("R4", "gate_p held clk3", gate_p, 1'b0);
        nclk(1);
        chk("R4", "gate_p rises after dead time", gate_p, 1'b1);
        pwm_in = 0;
        nclk(1);
        chk("R4", "gate_p falls after one clock", gate_p, 1'b0);
        chk("R4", "gate_n rises with zero dead time", gate_n, 1'b1);

        // R5: swap at terminal count
        configure(3'd0, 3'd0, 3'd1, 3'd1, '0, '0, 1'b1, 2'd0, 2'd0);
        start_run();
        nclk(1);
        chk("R5", "swapped to alternate", gate_p, 1'b1);
        pulse_tc();
        nclk(1);
        chk("R5", "swapped back", gate_p, 1'b0);
        configure(3'd0, 3'd0, 3'd1, 3'd1, '0, '0, 1'b0, 2'd0, 2'd0);
        start_run();
        pulse_tc();
        nclk(1);
        chk("R5", "no swap when disabled", gate_p, 1'b0);

        // R6: disable forces safe pattern one clock later
        configure(3'd1, 3'd1, 3'd1, 3'd1, '0, '0, 1'b0, 2'd0, 2'd0);
        start_run();
        nclk(1);
        chk("R6", "running gate_p", gate_p, 1'b1);
        cnt_running = 0;
        nclk(1);
        chk("R6", "stopped gate_p", gate_p, 1'b0);
        chk("R6", "stopped gate_n", gate_n, 1'b0);

        // R7 R10: next-clock kill and resume on terminal count
        configure(3'd1, 3'd1, 3'd1, 3'd1, '0, '0, 1'b0, 2'd0, 2'd0);
        start_run();
        nclk(1);
        kill_in = 1;
        #1;
        chk("R7", "next-clock mode not yet killed", gate_p, 1'b1);
        nclk(1);
        chk("R7", "next-clock kill gate_p", gate_p, 1'b0);
        chk("R7", "next-clock kill gate_n", gate_n, 1'b0);
        kill_in = 0;
        nclk(3);
        chk("R10", "held safe until tc", gate_p, 1'b0);
        pulse_tc();
        chk("R10", "resumed after tc", gate_p, 1'b1);

        // R7: immediate kill
        configure(3'd1, 3'd1, 3'd1, 3'd1, '0, '0, 1'b0, 2'd0, 2'd1);
        start_run();
        nclk(1);
        kill_in = 1;
        #1;
        chk("R7", "immediate kill gate_p", gate_p, 1'b0);
        chk("R7", "immediate kill gate_n", gate_n, 1'b0);
        nclk(1);

        // R8: terminal-count synchronous kill with primary dead time 2
        configure(3'd1, 3'd1, 3'd1, 3'd1, 8'd2, 8'd0, 1'b0, 2'd0, 2'd2);
        start_run();
        nclk(4);
        kill_in = 1;
        nclk(3);
        chk("R8", "no suppression before tc", gate_p, 1'b1);
        pulse_tc();
        chk("R8", "still running tc+1", gate_p, 1'b1);
        nclk(1);
        chk("R8", "still running tc+2", gate_n, 1'b1);
        nclk(1);
        chk("R8", "suppressed after dead time", gate_p, 1'b0);
        chk("R8", "complement suppressed", gate_n, 1'b0);

        // R9: staggered kill, complementary dead time 2, safe pattern both high
        configure(3'd0, 3'd0, 3'd0, 3'd0, 8'd0, 8'd2, 1'b0, 2'd3, 2'd3);
        start_run();
        nclk(2);
        kill_in = 1;
        nclk(1);
        chk("R9", "primary suppressed at once", gate_p, 1'b1);
        chk("R9", "complement not yet", gate_n, 1'b0);
        nclk(1);
        chk("R9", "complement still running", gate_n, 1'b0);
        nclk(1);
        chk("R9", "complement suppressed", gate_n, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule